// File: doc/BRIEF.md
# AAL5 Cell Segmentation Engine

This block turns packet data into 53-byte ATM cells. Software, or a descriptor engine upstream, hands it one buffer descriptor at a time. A descriptor gives the buffer's byte count and its start and end flags. The first descriptor of a packet also carries the 32-bit cell header word, the 32-bit control/length word and the adaptation mode. The data bytes of the buffer then follow on a byte-wide stream. The engine fills a 48-byte payload store. It sends each full cell with a header and HEC on a byte-wide output stream.

In AAL5 mode the engine keeps a CRC-32 and a length count across the whole packet. At the end of the packet it places the padding and the 8-byte trailer. If the trailer does not fit in the current cell, it adds one extra cell that carries only padding and the trailer. In transparent mode it pads the last cell with zeros and adds no trailer. A per-packet option decides whether that last cell carries the end-of-packet PTI marking.

Back-pressure rules:
- All three streams transfer on a clock edge where valid and ready are both high.
- `desc_ready` is high only while the engine waits for a descriptor.
- `in_ready` is high only while the current buffer still has bytes and the cell under construction has room.
- The output holds `out_valid` and `out_data` steady until `out_ready` accepts the byte.
- A ready output never depends on the valid input of the same stream.

Top module: `aal5_seg_engine`

## Requirements
- R1: After reset `desc_ready` is 1, `in_ready` is 0 and `out_valid` is 0.
- R2: Every cell leaves as exactly 53 bytes: 4 header bytes most significant first, then the HEC, then 48 payload bytes. `out_last` is 1 on the 53rd byte only.
- R3: The HEC byte is a CRC-8 (polynomial x^8+x^2+x+1, initial value 0) over the 4 header bytes of that cell, XORed with 0x55.
- R4: Data bytes appear in payload order from payload offset 0, with no gaps across buffer boundaries. A cell is sent only once all 48 of its payload bytes are written.
- R5: In AAL5 mode the trailer goes into the same cell when at most 40 payload bytes hold data at end of packet. Zeros fill up to offset 39, the control/length word sits at offsets 40 to 43 and the inverted CRC at offsets 44 to 47. Both words go most significant byte first.
- R6: In AAL5 mode, when more than 40 bytes of the final cell hold data, that cell is zero-padded to 48 bytes and sent. A further cell follows with 40 zero bytes and then the trailer.
- R7: The CRC-32 uses the reflected form of polynomial 0x04C11DB7 (0xEDB88320 shifted right). It is preset to all ones on a start descriptor. It runs over every payload byte of the packet's cells except the last four, and the transmitted value is its one's complement.
- R8: The transmitted control/length word equals the word latched at packet start, with its low 16 bits increased by the packet's data byte count, modulo 2^16.
- R9: In AAL5 mode the cell that carries the trailer has header bit 3 cleared and header bit 1 set. Every other cell carries the header exactly as latched.
- R10: In transparent mode the last cell is zero-padded to 48 bytes and has no trailer. Its header gets the R9 change only when the option flag was set at packet start. A packet of 48*k bytes (k>0) produces exactly k cells, and an empty packet produces one zero cell.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine accepts a descriptor |
| desc_sop | input | 1 | Descriptor is the first buffer of a packet |
| desc_eop | input | 1 | Descriptor is the last buffer of a packet |
| desc_len | input | 16 | Byte count of the buffer |
| desc_hdr | input | 32 | Cell header word (used when `desc_sop`) |
| desc_ctrl | input | 32 | Control/length word (used when `desc_sop`) |
| desc_aal5 | input | 1 | 1 = AAL5 mode, 0 = transparent (used when `desc_sop`) |
| desc_pti_opt | input | 1 | Transparent mode: mark the last cell as end of packet |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Engine takes a data byte |
| in_data | input | 8 | Data byte |
| out_valid | output | 1 | Cell byte offered |
| out_ready | input | 1 | Downstream accepts the cell byte |
| out_data | output | 8 | Cell byte |
| out_last | output | 1 | Last byte of a cell |

## Verification
The bench targets the fit boundary: packets that leave exactly 40 bytes in the last cell, and packets that leave 41 or exactly 48. An off-by-one there either pushes a trailer into a cell where it does not fit or adds a needless extra cell, so the cell count and the payload offsets both go wrong. Transparent packets of exact multiples of 48 catch a design that appends a spurious padding cell. Packets split over many short buffers catch data or CRC state lost at a buffer boundary in mid-cell. Random output stalls catch a byte that changes or is dropped while held. A wrong CRC preset, a wrong reflection or a wrong length accumulation shows up in the trailer bytes. Wrong PTI handling shows up in the header of the last cell, or of a cell that is not last.

// File: rtl/aal5_seg_pkg.sv
package aal5_seg_pkg;
  typedef enum logic [2:0] {
    ST_DESC,
    ST_FILL,
    ST_PAD,
    ST_TRL,
    ST_SEND
  } seg_state_t;

  localparam int HDR_WORD_BYTES = 4;
  localparam int HDR_TOTAL      = HDR_WORD_BYTES + 1;
  localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  HEC_POLY        = 8'h07;
  localparam logic [7:0]  HEC_COSET       = 8'h55;
  localparam logic [31:0] PTI_NET_MASK    = 32'h0000_0008;
  localparam logic [31:0] PTI_EOP_MASK    = 32'h0000_0002;
endpackage

// File: rtl/aal5_crc32_step.sv
module aal5_crc32_step
  import aal5_seg_pkg::*;
(
  input  logic [31:0] crc_in,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_out
);
  always_comb begin
    logic [31:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ byte_in[i];
      c  = (c >> 1) ^ (fb ? CRC32_POLY_REFL : 32'h0);
    end
    crc_out = c;
  end
endmodule

// File: rtl/atm_hec_calc.sv
module atm_hec_calc
  import aal5_seg_pkg::*;
(
  input  logic [31:0] hdr,
  output logic [7:0]  hec
);
  always_comb begin
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ hdr[i];
      c  = {c[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
    end
    hec = c ^ HEC_COSET;
  end
endmodule

// File: rtl/aal5_cell_store.sv
module aal5_cell_store #(
  parameter int DEPTH  = 48,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/aal5_seg_engine.sv
module aal5_seg_engine
  import aal5_seg_pkg::*;
#(
  parameter int PAY_BYTES = 48,
  parameter int TRL_BYTES = 8,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic             desc_sop,
  input  logic             desc_eop,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [31:0]      desc_hdr,
  input  logic [31:0]      desc_ctrl,
  input  logic             desc_aal5,
  input  logic             desc_pti_opt,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  localparam int CELL_BYTES = HDR_TOTAL + PAY_BYTES;
  localparam int POS_W      = $clog2(PAY_BYTES + 1);
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int ADDR_W     = $clog2(PAY_BYTES);
  localparam logic [POS_W-1:0] POS_FULL = POS_W'(PAY_BYTES);
  localparam logic [POS_W-1:0] POS_TRL  = POS_W'(PAY_BYTES - TRL_BYTES);
  localparam logic [POS_W-1:0] POS_CRC  = POS_W'(PAY_BYTES - 4);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_HEC  = IDX_W'(HDR_WORD_BYTES);

  seg_state_t       st;
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] rem;
  logic             eop_q, aal5_q, opt_q, fit_q, last_q, pti_q, pend_q;
  logic [31:0]      hdr_q, ctrl_q, crc_q, crc_nxt, shdr;
  logic [7:0]       hec, rd_data, wr_data, trl_byte;
  logic             take_ok, acc_byte, pad_wr, trl_wr, wr_en, crc_en;
  logic [POS_W-1:0] pad_tgt, trl_k;
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0]       hsel;

  // Datapath controls
  assign take_ok  = (rem != '0) && (pos != POS_FULL);
  assign desc_ready = (st == ST_DESC);
  assign in_ready = (st == ST_FILL) && take_ok;
  assign acc_byte = in_ready && in_valid;
  assign pad_tgt  = fit_q ? POS_TRL : POS_FULL;
  assign pad_wr   = (st == ST_PAD) && (pos != pad_tgt);
  assign trl_wr   = (st == ST_TRL) && (pos != POS_FULL);
  assign wr_en    = acc_byte || pad_wr || trl_wr;
  assign crc_en   = wr_en && !(trl_wr && pos >= POS_CRC);

  // Trailer byte: control word then inverted CRC, MSB first
  assign trl_k    = pos - POS_TRL;
  assign trl_byte = (trl_k < POS_W'(4)) ? ctrl_q[{2'd3 - trl_k[1:0], 3'b000} +: 8]
                                        : ~crc_q[{2'd3 - trl_k[1:0], 3'b000} +: 8];
  assign wr_data  = acc_byte ? in_data : (pad_wr ? 8'h00 : trl_byte);

  aal5_crc32_step u_crc (.crc_in(crc_q), .byte_in(wr_data), .crc_out(crc_nxt));

  aal5_cell_store #(.DEPTH(PAY_BYTES)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(ADDR_W'(pos)), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Output framing
  assign shdr = pti_q ? ((hdr_q & ~PTI_NET_MASK) | PTI_EOP_MASK) : hdr_q;
  atm_hec_calc u_hec (.hdr(shdr), .hec(hec));
  assign rd_addr   = ADDR_W'(idx - IDX_W'(HDR_TOTAL));
  assign hsel      = 2'd3 - idx[1:0];
  assign out_valid = (st == ST_SEND);
  assign out_last  = out_valid && (idx == IDX_LAST);
  always_comb begin
    if (idx < IDX_HEC)       out_data = shdr[{hsel, 3'b000} +: 8];
    else if (idx == IDX_HEC) out_data = hec;
    else                     out_data = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_DESC; pos <= '0; idx <= '0; rem <= '0;
      eop_q <= 1'b0; aal5_q <= 1'b0; opt_q <= 1'b0; fit_q <= 1'b0;
      last_q <= 1'b0; pti_q <= 1'b0; pend_q <= 1'b0;
      hdr_q <= '0; ctrl_q <= '0; crc_q <= '1;
    end else begin
      if (wr_en)  pos   <= pos + POS_W'(1);
      if (crc_en) crc_q <= crc_nxt;
      unique case (st)
        ST_DESC: if (desc_valid) begin
          rem   <= desc_len;
          eop_q <= desc_eop;
          if (desc_sop) begin
            hdr_q <= desc_hdr; ctrl_q <= desc_ctrl; crc_q <= '1;
            aal5_q <= desc_aal5; opt_q <= desc_pti_opt;
          end
          st <= ST_FILL;
        end
        ST_FILL: begin
          if (acc_byte) begin
            rem <= rem - LEN_W'(1);
            ctrl_q[LEN_W-1:0] <= ctrl_q[LEN_W-1:0] + LEN_W'(1);
          end else if (!take_ok) begin
            if (pos == POS_FULL) begin
              last_q <= eop_q && (rem == '0) && !aal5_q;
              pti_q  <= eop_q && (rem == '0) && !aal5_q && opt_q;
              pend_q <= eop_q && (rem == '0) && aal5_q;
              st     <= ST_SEND;
            end else if (!eop_q) begin
              st <= ST_DESC;
            end else begin
              fit_q <= aal5_q && (pos <= POS_TRL);
              st    <= ST_PAD;
            end
          end
        end
        ST_PAD: if (pos == pad_tgt) begin
          if (fit_q) st <= ST_TRL;
          else begin
            last_q <= !aal5_q; pti_q <= !aal5_q && opt_q; pend_q <= aal5_q;
            st <= ST_SEND;
          end
        end
        ST_TRL: if (pos == POS_FULL) begin
          last_q <= 1'b1; pti_q <= 1'b1; pend_q <= 1'b0; st <= ST_SEND;
        end
        ST_SEND: if (out_ready) begin
          if (idx == IDX_LAST) begin
            idx <= '0; pos <= '0;
            if (pend_q)      begin fit_q <= 1'b1; pend_q <= 1'b0; st <= ST_PAD; end
            else if (last_q) st <= ST_DESC;
            else             st <= ST_FILL;
          end else idx <= idx + IDX_W'(1);
        end
        default: st <= ST_DESC;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11
  AST_SEND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pos == POS_FULL); // R4
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ctrl_q[LEN_W-1:0] == $past(ctrl_q[LEN_W-1:0]) + LEN_W'(1)); // R8
  AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && desc_sop |=> crc_q == 32'hFFFF_FFFF); // R7
  AST_TRL_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_TRL |-> pos >= POS_TRL); // R5
  AST_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> pos < POS_FULL && !out_valid); // R4
endmodule

// File: tb/test_aal5_seg_engine.sv
module test_aal5_seg_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        desc_valid = 0, desc_sop = 0, desc_eop = 0, desc_aal5 = 0, desc_pti_opt = 0;
  logic [15:0] desc_len = '0;
  logic [31:0] desc_hdr = '0, desc_ctrl = '0;
  logic        in_valid = 0, out_ready = 0;
  logic [7:0]  in_data = '0;
  logic        desc_ready, in_ready, out_valid, out_last;
  logic [7:0]  out_data;

  int checks = 0, failures = 0, cycles = 0;
  byte unsigned exp_b[$];
  int           exp_r[$];
  byte unsigned pkt[$];

  always #4 clk = ~clk;

  aal5_seg_engine i_aal5_seg_engine (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_sop(desc_sop), .desc_eop(desc_eop), .desc_len(desc_len), .desc_hdr(desc_hdr),
    .desc_ctrl(desc_ctrl), .desc_aal5(desc_aal5), .desc_pti_opt(desc_pti_opt),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic byte unsigned hec_of(logic [31:0] h);
    byte unsigned c = 0;
    for (int b = 3; b >= 0; b--) begin
      c = c ^ h[8*b +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? byte'((c << 1) ^ 8'h07) : byte'(c << 1);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [31:0] crc_byte(logic [31:0] c, byte unsigned d);
    c = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  // Region codes: 0 header, 1 HEC, 2 data, 3 padding, 4 control word, 5 CRC
  task automatic build_expect(int len, bit aal5, bit opt, logic [31:0] hdr,
                              logic [31:0] ctrl, output int ncell);
    byte unsigned pay[$];
    int           reg_of[$];
    logic [31:0]  crc = 32'hFFFF_FFFF, cw, h;
    int           total;
    if (aal5) ncell = (len + 8 + 47) / 48;
    else      ncell = (len == 0) ? 1 : (len + 47) / 48;
    total = ncell * 48;
    for (int i = 0; i < len; i++) begin pay.push_back(pkt[i]); reg_of.push_back(2); end
    while (pay.size() < (aal5 ? total - 8 : total)) begin pay.push_back(0); reg_of.push_back(3); end
    if (aal5) begin
      cw = {ctrl[31:16], ctrl[15:0] + 16'(len)};
      for (int b = 3; b >= 0; b--) begin pay.push_back(cw[8*b +: 8]); reg_of.push_back(4); end
      for (int i = 0; i < total - 4; i++) crc = crc_byte(crc, pay[i]);
      crc = ~crc;
      for (int b = 3; b >= 0; b--) begin pay.push_back(crc[8*b +: 8]); reg_of.push_back(5); end
    end
    for (int c = 0; c < ncell; c++) begin
      h = hdr;
      if (c == ncell - 1 && (aal5 || opt)) h = (hdr & ~32'h8) | 32'h2;
      for (int b = 3; b >= 0; b--) begin exp_b.push_back(h[8*b +: 8]); exp_r.push_back(0); end
      exp_b.push_back(hec_of(h)); exp_r.push_back(1);
      for (int i = 0; i < 48; i++) begin exp_b.push_back(pay[c*48+i]); exp_r.push_back(reg_of[c*48+i]); end
    end
  endtask

  task automatic drive(int len, bit aal5, bit opt, logic [31:0] hdr, logic [31:0] ctrl);
    int left = len, p = 0, chunk;
    bit first = 1;
    do begin
      chunk = (left == 0) ? 0 : 1 + int'($urandom % ((left < 60) ? left : 60));
      @(negedge clk);
      desc_valid = 1; desc_sop = first; desc_eop = (chunk == left); desc_len = 16'(chunk);
      desc_hdr = hdr; desc_ctrl = ctrl; desc_aal5 = aal5; desc_pti_opt = opt;
      while (!desc_ready) @(negedge clk);
      @(negedge clk);
      desc_valid = 0;
      for (int i = 0; i < chunk; i++) begin
        if ($urandom % 3 == 0) begin in_valid = 0; @(negedge clk); end
        in_valid = 1; in_data = pkt[p];
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        p++;
      end
      in_valid = 0;
      left -= chunk; first = 0;
    end while (left > 0);
  endtask

  task automatic receive(int ncell, bit aal5, string ctag);
    int got = 0, cells = 0, n = exp_b.size();
    bit holding = 0;
    byte unsigned hold = 0;
    string tg;
    while (got < n) begin
      @(negedge clk);
      if (holding) chk(out_valid && out_data == hold, "R11", "held byte", int'(out_data), int'(hold));
      holding = 0;
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        case (exp_r[got])
          0: tg = aal5 ? "R9" : "R10";
          1: tg = "R3";
          2: tg = "R4";
          3: tg = aal5 ? "R6" : "R10";
          4: tg = "R8";
          default: tg = "R7";
        endcase
        chk(out_data == exp_b[got], tg, $sformatf("byte %0d", got), int'(out_data), int'(exp_b[got]));
        chk(out_last == ((got % 53) == 52), "R2", "last flag", int'(out_last), int'((got % 53) == 52));
        if (out_last) cells++;
        got++;
      end else if (out_valid) begin
        holding = 1; hold = out_data;
      end
    end
    @(negedge clk);
    out_ready = 0;
    chk(cells == ncell, ctag, "cell count", cells, ncell);
    repeat (3) @(negedge clk);
    chk(!out_valid, ctag, "no extra cell", int'(out_valid), 0);
  endtask

  task automatic run_pkt(int len, bit aal5, bit opt, string ctag);
    logic [31:0] hdr = $urandom, ctrl = {$urandom, 16'(($urandom % 4) * 100)} ;
    int ncell;
    pkt.delete(); exp_b.delete(); exp_r.delete();
    for (int i = 0; i < len; i++) pkt.push_back(byte'($urandom));
    build_expect(len, aal5, opt, hdr, ctrl, ncell);
    fork
      drive(len, aal5, opt, hdr, ctrl);
      receive(ncell, aal5, ctag);
    join
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int seed = $urandom(32'd2024);
    int len;
    bit aal5;
    repeat (3) @(negedge clk);
    chk(desc_ready == 1 && in_ready == 0 && out_valid == 0, "R1", "reset outputs",
        int'({desc_ready, in_ready, out_valid}), 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(desc_ready == 1 && out_valid == 0, "R1", "after release",
        int'({desc_ready, out_valid}), 2'b10);
    // Directed corner cases
    run_pkt(0,  1, 0, "R5");
    run_pkt(40, 1, 0, "R5");
    run_pkt(41, 1, 0, "R6");
    run_pkt(48, 1, 0, "R6");
    run_pkt(88, 1, 0, "R5");
    run_pkt(89, 1, 0, "R6");
    run_pkt(0,  0, 1, "R10");
    run_pkt(48, 0, 0, "R10");
    run_pkt(96, 0, 1, "R10");
    run_pkt(50, 0, 1, "R10");
    run_pkt(20, 0, 0, "R10");
    // Constrained random
    for (int t = 0; t < 30; t++) begin
      len  = int'($urandom % 150);
      aal5 = ($urandom % 3) != 0;
      run_pkt(len, aal5, 1'($urandom), aal5 ? (((len % 48) <= 40 && !(len > 0 && len % 48 == 0)) ? "R5" : "R6") : "R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule